// File: doc/BRIEF.md
# Serial Line Controller with Optional Character Queues

This block is a byte-oriented asynchronous serial port. It has one transmit line and one receive line, and each direction can hold characters either in a single buffer or in a 16-entry queue. Software reaches it through a small synchronous register bus with three locations.

- **Data location (address 0).** Writing it loads the next character to send. Reading it takes the oldest received character. When the divisor-access bit in the control word is set, the same location instead holds the 16-bit baud divisor.
- **Control word (address 1).** It holds a break bit, the divisor-access bit and the queue-enable bit, plus two strobe bits. One strobe empties the receive queue and the other empties the transmit queue.
- **Status word (address 2).** It reports transmit-empty, receive-available, overrun and transmitter-idle.

A break holds only the transmit pin at the spacing level. The transmitter keeps shifting and keeps draining its buffer while the break is on. Emptying a queue never touches the character already sitting in a shift register.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0000, the divisor is 1, the status word reads 0x0009 and `txd` is high.
- R2: Address 1 is the control word. Its fields are break at bit 6, divisor access at bit 7 and queue enable at bit 8. Bits 9 and 10 are clear strobes that always read back as 0.
- R3: While bit 7 is 1, address 0 reads and writes the 16-bit divisor. Such an access neither queues a transmit character nor removes a received one.
- R4: A frame is one start bit (0), then eight data bits with the least significant bit first, then one stop bit (1). Each bit lasts divisor × 16 clocks.
- R5: With bit 8 at 0, each direction holds one character. A transmit write made while that buffer is occupied is ignored.
- R6: With bit 8 at 1, each direction queues up to 16 characters and keeps them in arrival order. A transmit write made while the queue is full is ignored.
- R7: While bit 6 is 1, `txd` stays at 0. Transmission continues internally and buffered characters are still consumed, so the transmitter reaches idle.
- R8: The receiver samples each bit at its middle. A frame with a valid stop bit is stored and sets status bit 1. Reading address 0 removes the oldest character.
- R9: A character that completes while the receive buffer is full is dropped and sets status bit 2. That bit stays set until the status word is read.
- R10: Writing 1 to bit 9 empties the receive buffer. A character still being received at that moment is stored when its stop bit completes.
- R11: Writing 1 to bit 10 empties the transmit buffer. A character already in the shift register is sent in full.
- R12: Any change of bit 8 empties both buffers.
- R13: Status bit 0 is 1 when the transmit buffer is empty. Status bit 3 is 1 when both the transmit buffer and the shift register are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; on address 0 it pops a received character |
| bus_rdata | output | 16 | Read data for the selected register, combinational |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
A wrong queue count or pointer shows up on the next read of address 0 or of the status word. It also shows up one frame time later on `txd`, as a missing, repeated or reordered character. Several faults are only visible on the line, and only after about 160 clocks at divisor 1: a break that stops the shifter, a clear that reaches a shift register, or a queue that was not flushed when the enable bit changed. The bench therefore decodes whole frames and checks that the line stays quiet for a further frame time.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTRL_BRK   = 6;
  localparam int CTRL_DLA   = 7;
  localparam int CTRL_FEN   = 8;
  localparam int CTRL_RXCLR = 9;
  localparam int CTRL_TXCLR = 10;

  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} line_state_t;

  // clocks per serial bit; a zero divisor behaves as one
  function automatic logic [31:0] bit_ticks(input logic [31:0] div, input logic [31:0] osr);
    logic [31:0] d;
    d = (div == 32'd0) ? 32'd1 : div;
    return d * osr;
  endfunction

  // offset from the start edge to the middle of the start bit
  function automatic logic [31:0] half_ticks(input logic [31:0] ticks);
    return ticks >> 1;
  endfunction

endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = single ? (count != '0) : (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_fifo_pkg::*;
#(
  parameter int W  = 8,
  localparam int BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  ticks,
  input  logic         avail,
  input  logic [W-1:0] data,
  output logic         load,
  output logic         line,
  output logic         busy
);

  line_state_t   state;
  logic [31:0]   cnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shreg;
  logic          bit_end;

  assign load    = (state == LN_IDLE) && avail;
  assign busy    = (state != LN_IDLE);
  assign bit_end = (cnt >= ticks - 32'd1);

  always_comb begin
    case (state)
      LN_START: line = 1'b0;
      LN_DATA:  line = shreg[0];
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LN_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else if (state == LN_IDLE) begin
      cnt <= '0;
      if (avail) begin
        shreg <= data;
        state <= LN_START;
      end
    end else if (!bit_end) begin
      cnt <= cnt + 32'd1;
    end else begin
      cnt <= '0;
      case (state)
        LN_START: begin
          state <= LN_DATA;
          bitn  <= '0;
        end
        LN_DATA: begin
          shreg <= shreg >> 1;
          if (bitn == BW'(W - 1)) state <= LN_STOP;
          else bitn <= bitn + BW'(1);
        end
        default: state <= LN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_fifo_pkg::*;
#(
  parameter int W  = 8,
  localparam int BW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [31:0]  ticks,
  input  logic         rxd,
  output logic         done,
  output logic [W-1:0] data
);

  line_state_t   state;
  logic [31:0]   cnt;
  logic [BW-1:0] bitn;
  logic [W-1:0]  shreg;
  logic          s1, s2;

  assign data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= LN_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        LN_IDLE: begin
          cnt <= '0;
          if (!s2) state <= LN_START;
        end
        LN_START: begin
          if (cnt >= half_ticks(ticks) - 32'd1) begin
            cnt   <= '0;
            bitn  <= '0;
            state <= s2 ? LN_IDLE : LN_DATA;
          end else cnt <= cnt + 32'd1;
        end
        LN_DATA: begin
          if (cnt >= ticks - 32'd1) begin
            cnt   <= '0;
            shreg <= {s2, shreg[W-1:1]};
            if (bitn == BW'(W - 1)) state <= LN_STOP;
            else bitn <= bitn + BW'(1);
          end else cnt <= cnt + 32'd1;
        end
        default: begin
          if (cnt >= ticks - 32'd1) begin
            cnt   <= '0;
            done  <= s2;
            state <= LN_IDLE;
          end else cnt <= cnt + 32'd1;
        end
      endcase
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter int DIV_W   = 16,
  parameter int OSR     = 16,
  parameter int DIV_RST = 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [15:0] bus_rdata,
  output logic        txd,
  input  logic        rxd
);

  logic             brk_q, dla_q, fen_q, ovr_q;
  logic [DIV_W-1:0] div_q;
  logic [31:0]      ticks;

  logic wr_data, wr_ctrl, rd_data, rd_stat;
  logic ev_tx_push, ev_rx_pop, ev_fen_flip, ev_tx_clr, ev_rx_clr;
  logic ev_tx_load, ev_rx_done, ev_rx_drop;

  logic [W-1:0]  tx_head, rx_head, rx_word;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic          tx_line, tx_busy, tx_idle;

  assign ticks = bit_ticks(32'(div_q), 32'(OSR));

  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign rd_data = bus_rd && (bus_addr == ADDR_DATA);
  assign rd_stat = bus_rd && (bus_addr == ADDR_STAT);

  assign ev_tx_push  = wr_data && !dla_q;
  assign ev_rx_pop   = rd_data && !dla_q;
  assign ev_fen_flip = wr_ctrl && (bus_wdata[CTRL_FEN] != fen_q);
  assign ev_tx_clr   = wr_ctrl && (bus_wdata[CTRL_TXCLR] || ev_fen_flip);
  assign ev_rx_clr   = wr_ctrl && (bus_wdata[CTRL_RXCLR] || ev_fen_flip);
  assign ev_rx_drop  = ev_rx_done && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
      dla_q <= 1'b0;
      fen_q <= 1'b0;
      div_q <= DIV_W'(DIV_RST);
      ovr_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        brk_q <= bus_wdata[CTRL_BRK];
        dla_q <= bus_wdata[CTRL_DLA];
        fen_q <= bus_wdata[CTRL_FEN];
      end
      if (wr_data && dla_q) div_q <= bus_wdata[DIV_W-1:0];
      if (ev_rx_drop) ovr_q <= 1'b1;
      else if (rd_stat) ovr_q <= 1'b0;
    end
  end

  uart_sync_fifo #(.W(W), .DEPTH(DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_tx_clr), .single(!fen_q),
    .push(ev_tx_push), .pop(ev_tx_load), .wdata(bus_wdata[W-1:0]),
    .rdata(tx_head), .count(tx_count), .empty(tx_empty), .full(tx_full)
  );

  uart_sync_fifo #(.W(W), .DEPTH(DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .clr(ev_rx_clr), .single(!fen_q),
    .push(ev_rx_done), .pop(ev_rx_pop), .wdata(rx_word),
    .rdata(rx_head), .count(rx_count), .empty(rx_empty), .full(rx_full)
  );

  uart_tx_engine #(.W(W)) tx_i (
    .clk(clk), .rst_n(rst_n), .ticks(ticks), .avail(!tx_empty),
    .data(tx_head), .load(ev_tx_load), .line(tx_line), .busy(tx_busy)
  );

  uart_rx_engine #(.W(W)) rx_i (
    .clk(clk), .rst_n(rst_n), .ticks(ticks), .rxd(rxd),
    .done(ev_rx_done), .data(rx_word)
  );

  assign tx_idle = tx_empty && !tx_busy;
  assign txd     = brk_q ? 1'b0 : tx_line;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_DATA: begin
        if (dla_q) bus_rdata = 16'(div_q);
        else if (!rx_empty) bus_rdata = 16'(rx_head);
      end
      ADDR_CTRL: begin
        bus_rdata[CTRL_BRK] = brk_q;
        bus_rdata[CTRL_DLA] = dla_q;
        bus_rdata[CTRL_FEN] = fen_q;
      end
      ADDR_STAT: bus_rdata = {12'd0, tx_idle, ovr_q, !rx_empty, tx_empty};
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          brk_q,
  input logic          fen_q,
  input logic          ovr_q,
  input logic          tx_idle,
  input logic          ev_fen_flip,
  input logic          ev_tx_clr,
  input logic          ev_rx_clr,
  input logic          ev_rx_drop,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);

  assert_idle_line_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && !brk_q) |-> txd);

  assert_fen_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fen_flip |=> (tx_count == '0 && rx_count == '0));

  assert_rx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_clr |=> (rx_count == '0));

  assert_tx_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_clr |=> (tx_count == '0));

  assert_tx_capacity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= (fen_q ? CW'(DEPTH) : CW'(1)));

  assert_overrun_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_drop |=> ovr_q);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .txd(txd), .brk_q(brk_q), .fen_q(fen_q),
  .ovr_q(ovr_q), .tx_idle(tx_idle), .ev_fen_flip(ev_fen_flip),
  .ev_tx_clr(ev_tx_clr), .ev_rx_clr(ev_rx_clr), .ev_rx_drop(ev_rx_drop),
  .tx_count(tx_count), .rx_count(rx_count)
);

// File: tb/uart_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb_top;

  localparam int P = 16;  // divisor 1 x 16 clocks per bit (R4)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        txd;
  logic        rx_drv = 1'b1;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_fifo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .txd(txd), .rxd(rx_drv)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // decode one frame from txd; ok=0 if start/stop wrong or no frame seen
  task automatic cap_tx(output logic [7:0] b, output logic ok);
    int waited = 0;
    ok = 1'b1; b = '0;
    @(negedge clk);
    while (txd !== 1'b0 && waited < 3000) begin
      @(negedge clk); waited++;
    end
    if (waited >= 3000) ok = 1'b0;
    repeat (P/2) @(negedge clk);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (P) @(negedge clk);
      b[i] = txd;
    end
    repeat (P) @(negedge clk);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic watch_idle(input int n, output logic ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(negedge clk);
    rx_drv = 1'b0;
    repeat (P) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_drv = b[i];
      repeat (P) @(negedge clk);
    end
    rx_drv = 1'b1;
    repeat (P + 4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    bus_read(2'd1, d); check("R1 ctrl reset", d, 16'h0000);
    bus_read(2'd2, d); check("R1 status reset", d, 16'h0009);
    check("R1 txd idle high", {15'd0, txd}, 16'h0001);
  endtask

  task automatic t_divisor;
    logic [15:0] d;
    bus_write(2'd1, 16'h0080);
    bus_read(2'd0, d); check("R1 divisor reset", d, 16'h0001);
    bus_write(2'd0, 16'h1234);
    bus_read(2'd0, d); check("R3 divisor readback", d, 16'h1234);
    bus_read(2'd1, d); check("R2 ctrl bit7 readback", d, 16'h0080);
    bus_read(2'd2, d); check("R3 no tx push via divisor", d, 16'h0009);
    bus_write(2'd0, 16'h0001);
    bus_write(2'd1, 16'h0000);
  endtask

  task automatic t_tx_single;
    logic [7:0] b0, b1; logic k0, k1, idle; logic [15:0] st;
    fork
      begin cap_tx(b0, k0); cap_tx(b1, k1); watch_idle(3*P*10, idle); end
      begin
        bus_write(2'd0, 16'h00A5);
        bus_write(2'd0, 16'h003C);
        bus_write(2'd0, 16'h0077);
        bus_read(2'd2, st);
      end
    join
    check("R13 status holding full", st, 16'h0000);
    check("R4 frame1 ok", {15'd0, k0}, 16'h0001);
    check("R4 frame1 data", {8'd0, b0}, 16'h00A5);
    check("R5 frame2 data", {8'd0, b1}, 16'h003C);
    check("R5 third write dropped", {15'd0, idle}, 16'h0001);
    bus_read(2'd2, st); check("R13 idle after tx", st, 16'h0009);
  endtask

  task automatic t_tx_fifo;
    logic [7:0] got [17]; logic ok [17]; logic idle;
    bus_write(2'd1, 16'h0100);
    fork
      begin
        for (int i = 0; i < 17; i++) cap_tx(got[i], ok[i]);
        watch_idle(3*P*10, idle);
      end
      begin
        for (int i = 0; i < 18; i++) bus_write(2'd0, 16'(8'h10 + i));
      end
    join
    for (int i = 0; i < 17; i++) begin
      check("R6 fifo order", {7'd0, ok[i], got[i]}, {7'd0, 1'b1, 8'(8'h10 + i)});
    end
    check("R6 write to full dropped", {15'd0, idle}, 16'h0001);
  endtask

  task automatic t_break;
    logic [15:0] st; logic low = 1'b1;
    bus_write(2'd1, 16'h0140);
    bus_write(2'd0, 16'h0055);
    for (int i = 0; i < 220; i++) begin
      @(negedge clk);
      if (txd !== 1'b0) low = 1'b0;
    end
    check("R7 txd held low", {15'd0, low}, 16'h0001);
    bus_read(2'd2, st); check("R7 shifter ran during break", st, 16'h0009);
    bus_write(2'd1, 16'h0100);
    @(negedge clk);
    check("R7 txd released", {15'd0, txd}, 16'h0001);
  endtask

  task automatic t_rx_basic;
    logic [15:0] d;
    bus_write(2'd1, 16'h0000);
    send_rx(8'hC3);
    bus_read(2'd2, d); check("R8 rx available", d, 16'h000B);
    bus_read(2'd0, d); check("R8 rx data", d, 16'h00C3);
    bus_read(2'd2, d); check("R8 rx popped", d, 16'h0009);
  endtask

  task automatic t_overrun;
    logic [15:0] d;
    send_rx(8'h11);
    send_rx(8'h22);
    bus_read(2'd2, d); check("R9 overrun flagged", d, 16'h000F);
    bus_read(2'd0, d); check("R5 first char kept", d, 16'h0011);
    bus_read(2'd2, d); check("R9 overrun cleared by status read", d, 16'h0009);
  endtask

  task automatic t_rx_fifo;
    logic [15:0] d;
    bus_write(2'd1, 16'h0100);
    send_rx(8'hA1); send_rx(8'hB2); send_rx(8'hC3);
    bus_read(2'd0, d); check("R6 rx order 0", d, 16'h00A1);
    bus_read(2'd0, d); check("R6 rx order 1", d, 16'h00B2);
    bus_read(2'd0, d); check("R6 rx order 2", d, 16'h00C3);
    bus_read(2'd2, d); check("R8 rx drained", d, 16'h0009);
  endtask

  task automatic t_rx_clear;
    logic [15:0] d;
    send_rx(8'h5A);
    fork
      send_rx(8'h6B);
      begin repeat (60) @(negedge clk); bus_write(2'd1, 16'h0300); end
    join
    bus_read(2'd0, d); check("R10 in-flight char kept", d, 16'h006B);
    bus_read(2'd2, d); check("R10 old char cleared", d, 16'h0009);
    bus_read(2'd1, d); check("R2 clear bits read 0", d, 16'h0100);
  endtask

  task automatic t_tx_clear;
    logic [7:0] b; logic ok, idle; logic [15:0] d;
    fork
      begin cap_tx(b, ok); watch_idle(3*P*10, idle); end
      begin
        bus_write(2'd0, 16'h0081);
        bus_write(2'd0, 16'h0082);
        bus_write(2'd0, 16'h0083);
        bus_write(2'd1, 16'h0500);
      end
    join
    check("R11 shifter char sent", {7'd0, ok, b}, 16'h0181);
    check("R11 queued chars cleared", {15'd0, idle}, 16'h0001);
    bus_read(2'd2, d); check("R11 status after clear", d, 16'h0009);
  endtask

  task automatic t_fen_toggle;
    logic [15:0] d;
    send_rx(8'h01); send_rx(8'h02);
    bus_write(2'd0, 16'h00E1);
    bus_write(2'd0, 16'h00E2);
    bus_write(2'd0, 16'h00E3);
    bus_write(2'd1, 16'h0000);
    bus_read(2'd2, d); check("R12 both queues flushed", d, 16'h0001);
    repeat (12*P) @(negedge clk);
    bus_read(2'd2, d); check("R12 nothing left to send", d, 16'h0009);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_divisor();
    t_tx_single();
    t_tx_fifo();
    t_break();
    t_rx_basic();
    t_overrun();
    t_rx_fifo();
    t_rx_clear();
    t_tx_clear();
    t_fen_toggle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule